// File: doc/BRIEF.md
# CAN Acceptance Filter Scan Engine

This block decides what happens to a received CAN frame by comparing its identifier against an ordered list of filter elements held in a word-addressed filter memory. A start strobe presents the identifier and a flag that marks it as 29-bit (extended) or 11-bit (standard). The engine then reads the standard list or the extended list through a synchronous read port, one word per cycle. Each list is placed by a start offset in words and an element count. Standard elements take one word each. Extended elements take two consecutive words each.

The first element that matches ends the scan. A one-cycle done pulse then reports a match flag, the element's action code, the index of the element, and, for dedicated-buffer elements, the buffer index and the two-bit store/debug selector. When nothing matches, or the list is empty, done is raised with the match flag low and every result field at zero. Choosing a default action is left to the caller. The caller also owns frame storage and FIFO management.

Top module: `can_filter_scan`

## Requirements
- R1: Elements are evaluated in ascending index order starting at element 0, and the scan ends at the first element that matches. Standard element k reports done k+2 cycles after the clock edge that accepts start. Extended element k reports done 2k+3 cycles after that edge.
- R2: One memory read is issued per cycle. Standard element k is read at word std_base+k. Extended element k is read at words ext_base+2k and then ext_base+2k+1. No read falls outside the active list's window.
- R3: Standard element word layout: kind in bits 31:30, action in bits 29:27, field A in bits 26:16, field B in bits 10:0, and bits 15:11 ignored.
- R4: Extended element layout: word 0 holds the action in bits 31:29 and field A in bits 28:0. Word 1 holds the kind in bits 31:30 and field B in bits 28:0, with bit 29 ignored.
- R5: Kind 00 matches when A ≤ ID ≤ B, with both bounds included.
- R6: Kind 01 matches when the ID equals A or equals B.
- R7: Kind 10 matches when the ID agrees with A on every bit where mask B is 1. Kind 11 never matches.
- R8: Action 111 ignores the kind field and matches only when the ID equals A. In that case buf_idx_o = B[5:0] and dbg_sel_o = B[10:9]. For every other result both of these outputs are zero.
- R9: Action 000 disables the element, so it never matches. Action 011 (reject) matches like any other element and is reported with hit_o high and action_o = 011. Actions 001 (FIFO 0) and 010 (FIFO 1) are reported unchanged.
- R10: When no element matches, or the selected list count is zero, done_o is raised with hit_o, action_o, elem_idx_o, buf_idx_o and dbg_sel_o all zero. A miss reports done cnt+1 cycles after start for a standard list, 2·cnt+1 for an extended list, and 1 for an empty list.
- R11: done_o is a single-cycle pulse, and after reset it is low with no read pending. A start strobe that arrives during a scan is ignored, and the result belongs to the scan already in progress.
- R12: The identifier and format are captured at start and may change afterwards. For a standard scan only id_i[10:0] is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan (accepted only when idle) |
| ext_i | input | 1 | 1 = 29-bit identifier, scan the extended list |
| id_i | input | 29 | Received identifier (standard uses bits 10:0) |
| std_base_i | input | ADDR_W | Word offset of standard list |
| std_cnt_i | input | CNT_W | Number of standard elements |
| ext_base_i | input | ADDR_W | Word offset of extended list |
| ext_cnt_i | input | CNT_W | Number of extended elements |
| mem_rd_o | output | 1 | Filter memory read enable |
| mem_addr_o | output | ADDR_W | Filter memory word address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the read |
| done_o | output | 1 | Scan finished (one-cycle pulse) |
| hit_o | output | 1 | An element matched |
| action_o | output | 3 | Action code of matching element |
| elem_idx_o | output | CNT_W | Index of matching element |
| buf_idx_o | output | 6 | Dedicated buffer index (action 111 only) |
| dbg_sel_o | output | 2 | Store/debug selector (action 111 only) |

## Verification
The assertions assume that read data arrives exactly one cycle after each read. They also assume that a list window stays inside the address space without wrapping, that start lasts a single cycle, and that the list configuration is held steady while a scan runs. The bench models the memory as a one-cycle synchronous array. Its lists sit well inside the 256-word space, and it changes list offsets and counts only between scans. It deliberately drives extra start pulses and alters id_i in the middle of a scan, because R11 and R12 say the design must tolerate both.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

  typedef enum logic [1:0] {
    KIND_RANGE = 2'b00,
    KIND_DUAL  = 2'b01,
    KIND_MASK  = 2'b10,
    KIND_RSVD  = 2'b11
  } kind_e;

  localparam logic [2:0] ACT_OFF    = 3'b000;
  localparam logic [2:0] ACT_FIFO0  = 3'b001;
  localparam logic [2:0] ACT_FIFO1  = 3'b010;
  localparam logic [2:0] ACT_REJECT = 3'b011;
  localparam logic [2:0] ACT_DEDBUF = 3'b111;

  localparam int ID_W  = 29;
  localparam int SID_W = 11;
  localparam int BUF_W = 6;

  typedef struct packed {
    logic [2:0]      act;
    kind_e           kind;
    logic [ID_W-1:0] fa;
    logic [ID_W-1:0] fb;
  } elem_t;

  // one-word element for 11-bit identifiers
  function automatic elem_t unpack_std(input logic [31:0] w);
    elem_t e;
    e.kind = kind_e'(w[31:30]);
    e.act  = w[29:27];
    e.fa   = {{(ID_W-SID_W){1'b0}}, w[26:16]};
    e.fb   = {{(ID_W-SID_W){1'b0}}, w[10:0]};
    return e;
  endfunction

  // two-word element for 29-bit identifiers
  function automatic elem_t unpack_ext(input logic [31:0] w0, input logic [31:0] w1);
    elem_t e;
    e.act  = w0[31:29];
    e.fa   = w0[28:0];
    e.kind = kind_e'(w1[31:30]);
    e.fb   = w1[28:0];
    return e;
  endfunction

  function automatic logic elem_hit(input elem_t e, input logic [ID_W-1:0] id);
    logic m;
    if (e.act == ACT_OFF)         m = 1'b0;
    else if (e.act == ACT_DEDBUF) m = (id == e.fa);
    else begin
      case (e.kind)
        KIND_RANGE: m = (id >= e.fa) && (id <= e.fb);
        KIND_DUAL:  m = (id == e.fa) || (id == e.fb);
        KIND_MASK:  m = ((id ^ e.fa) & e.fb) == '0;
        default:    m = 1'b0;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/can_flt_seq.sv
module can_flt_seq #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ext_i,
  input  logic [ADDR_W-1:0] std_base_i,
  input  logic [CNT_W-1:0]  std_cnt_i,
  input  logic [ADDR_W-1:0] ext_base_i,
  input  logic [CNT_W-1:0]  ext_cnt_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ext_o,
  output logic              w0_cap_o,
  output logic              elem_done_o,
  output logic              last_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  elem_idx_o
);

  localparam int WCNT_W = CNT_W + 1;

  typedef enum logic {S_IDLE = 1'b0, S_SCAN = 1'b1} state_e;

  state_e            state_q;
  logic              ext_q;
  logic [ADDR_W-1:0] base_q;
  logic [WCNT_W-1:0] nwords_q;
  logic [WCNT_W-1:0] issue_q;
  logic [WCNT_W-1:0] rword_q;
  logic              rv_q;

  assign busy_o   = (state_q == S_SCAN);
  assign accept_o = start_i && !busy_o;
  assign rd_o     = busy_o && (issue_q < nwords_q);
  assign addr_o   = base_q + ADDR_W'(issue_q);
  assign ext_o    = ext_q;
  assign empty_o  = busy_o && (nwords_q == '0);

  // an element completes on every word (standard) or every odd word (extended)
  assign elem_done_o = rv_q && (!ext_q || rword_q[0]);
  assign w0_cap_o    = rv_q && ext_q && !rword_q[0];
  assign last_o      = (rword_q == nwords_q - 1'b1);
  assign elem_idx_o  = ext_q ? rword_q[CNT_W:1] : rword_q[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      ext_q    <= 1'b0;
      base_q   <= '0;
      nwords_q <= '0;
      issue_q  <= '0;
      rword_q  <= '0;
      rv_q     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          rv_q <= 1'b0;
          if (start_i) begin
            ext_q    <= ext_i;
            base_q   <= ext_i ? ext_base_i : std_base_i;
            nwords_q <= ext_i ? {ext_cnt_i, 1'b0} : {1'b0, std_cnt_i};
            issue_q  <= '0;
            state_q  <= S_SCAN;
          end
        end
        default: begin
          if (rd_o) issue_q <= issue_q + 1'b1;
          rv_q    <= rd_o && !stop_i;
          rword_q <= issue_q;
          if (stop_i) state_q <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/can_flt_eval.sv
module can_flt_eval
  import can_flt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_i,
  input  logic             cap_i,
  input  logic [31:0]      rdata_i,
  input  logic [ID_W-1:0]  id_i,
  output logic             hit_o,
  output logic [2:0]       act_o,
  output logic [BUF_W-1:0] buf_o,
  output logic [1:0]       sel_o
);

  logic [31:0] w0_q;
  elem_t       e;
  logic        ded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     w0_q <= '0;
    else if (cap_i) w0_q <= rdata_i;
  end

  always_comb begin
    e     = ext_i ? unpack_ext(w0_q, rdata_i) : unpack_std(rdata_i);
    ded   = (e.act == ACT_DEDBUF);
    hit_o = elem_hit(e, id_i);
    act_o = e.act;
    buf_o = ded ? e.fb[BUF_W-1:0] : '0;
    sel_o = ded ? e.fb[10:9] : 2'b00;
  end

endmodule

// File: rtl/can_filter_scan.sv
module can_filter_scan
  import can_flt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ext_i,
  input  logic [28:0]       id_i,
  input  logic [ADDR_W-1:0] std_base_i,
  input  logic [CNT_W-1:0]  std_cnt_i,
  input  logic [ADDR_W-1:0] ext_base_i,
  input  logic [CNT_W-1:0]  ext_cnt_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output logic              hit_o,
  output logic [2:0]        action_o,
  output logic [CNT_W-1:0]  elem_idx_o,
  output logic [5:0]        buf_idx_o,
  output logic [1:0]        dbg_sel_o
);

  // named internal events
  logic              seq_busy;
  logic              seq_accept;
  logic              seq_ext;
  logic              seq_w0_cap;
  logic              seq_elem_done;
  logic              seq_last;
  logic              seq_empty;
  logic [CNT_W-1:0]  seq_idx;
  logic              ev_hit;
  logic [2:0]        ev_act;
  logic [BUF_W-1:0]  ev_buf;
  logic [1:0]        ev_sel;
  logic              elem_match;
  logic              scan_finish;
  logic [ID_W-1:0]   id_q;

  assign elem_match  = seq_elem_done && ev_hit;
  assign scan_finish = seq_empty || elem_match || (seq_elem_done && seq_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          id_q <= '0;
    else if (seq_accept) id_q <= ext_i ? id_i : {{(ID_W-SID_W){1'b0}}, id_i[SID_W-1:0]};
  end

  can_flt_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ext_i       (ext_i),
    .std_base_i  (std_base_i),
    .std_cnt_i   (std_cnt_i),
    .ext_base_i  (ext_base_i),
    .ext_cnt_i   (ext_cnt_i),
    .stop_i      (scan_finish),
    .busy_o      (seq_busy),
    .accept_o    (seq_accept),
    .rd_o        (mem_rd_o),
    .addr_o      (mem_addr_o),
    .ext_o       (seq_ext),
    .w0_cap_o    (seq_w0_cap),
    .elem_done_o (seq_elem_done),
    .last_o      (seq_last),
    .empty_o     (seq_empty),
    .elem_idx_o  (seq_idx)
  );

  can_flt_eval u_eval (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_i   (seq_ext),
    .cap_i   (seq_w0_cap),
    .rdata_i (mem_rdata_i),
    .id_i    (id_q),
    .hit_o   (ev_hit),
    .act_o   (ev_act),
    .buf_o   (ev_buf),
    .sel_o   (ev_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      hit_o      <= 1'b0;
      action_o   <= '0;
      elem_idx_o <= '0;
      buf_idx_o  <= '0;
      dbg_sel_o  <= '0;
    end else begin
      done_o <= scan_finish;
      if (scan_finish) begin
        hit_o      <= elem_match;
        action_o   <= elem_match ? ev_act  : '0;
        elem_idx_o <= elem_match ? seq_idx : '0;
        buf_idx_o  <= elem_match ? ev_buf  : '0;
        dbg_sel_o  <= elem_match ? ev_sel  : '0;
      end
    end
  end

endmodule

// File: rtl/can_flt_chk.sv
module can_flt_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              done_o,
  input logic              hit_o,
  input logic [2:0]        action_o,
  input logic [CNT_W-1:0]  elem_idx_o,
  input logic [5:0]        buf_idx_o,
  input logic [1:0]        dbg_sel_o
);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_scan_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy));

  assert_miss_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !hit_o) |-> (action_o == 3'b000 && elem_idx_o == '0 &&
                            buf_idx_o == '0 && dbg_sel_o == 2'b00));

  assert_no_disabled_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && hit_o) |-> (action_o != 3'b000));

  assert_bufidx_only_ded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && action_o != 3'b111) |-> (buf_idx_o == '0 && dbg_sel_o == 2'b00));

  assert_read_in_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> busy);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

endmodule

bind can_filter_scan can_flt_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (seq_busy),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .done_o     (done_o),
  .hit_o      (hit_o),
  .action_o   (action_o),
  .elem_idx_o (elem_idx_o),
  .buf_idx_o  (buf_idx_o),
  .dbg_sel_o  (dbg_sel_o)
);

// File: tb/tb_can_filter_scan.sv
module tb_can_filter_scan;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              ext_i = 1'b0;
  logic [28:0]       id_i = '0;
  logic [ADDR_W-1:0] std_base_i = 8'd8;
  logic [CNT_W-1:0]  std_cnt_i = '0;
  logic [ADDR_W-1:0] ext_base_i = 8'h40;
  logic [CNT_W-1:0]  ext_cnt_i = '0;
  logic              mem_rd_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [31:0]       mem_rdata_i = '0;
  logic              done_o, hit_o;
  logic [2:0]        action_o;
  logic [CNT_W-1:0]  elem_idx_o;
  logic [5:0]        buf_idx_o;
  logic [1:0]        dbg_sel_o;

  int checks = 0;
  int errors = 0;
  int rd_bad = 0;
  int win_lo = 0, win_hi = 0;
  bit finished = 0;

  logic [31:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  // one-cycle synchronous read memory; also polices the list window (R2)
  always @(posedge clk) begin
    if (mem_rd_o) begin
      mem_rdata_i <= mem[mem_addr_o];
      if (int'(mem_addr_o) < win_lo || int'(mem_addr_o) >= win_hi) rd_bad++;
    end
  end

  can_filter_scan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (.*);

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // bench-side reference: walks its own copy of the list
  task automatic model(input bit ex, input logic [28:0] idv,
                       output bit h, output int act, output int idx,
                       output int bi, output int sel, output int lat);
    int cnt, base;
    longint id, a, b, kind, ac;
    bit m;
    id  = ex ? longint'(idv) : longint'(idv) % 2048;
    cnt = ex ? int'(ext_cnt_i) : int'(std_cnt_i);
    base = ex ? int'(ext_base_i) : int'(std_base_i);
    h = 0; act = 0; idx = 0; bi = 0; sel = 0;
    lat = (cnt == 0) ? 1 : (ex ? 2*cnt + 1 : cnt + 1);
    for (int k = 0; k < cnt; k++) begin
      if (ex) begin
        ac   = mem[base + 2*k] / (1 << 29);
        a    = mem[base + 2*k] % (1 << 29);
        kind = mem[base + 2*k + 1] / (1 << 30);
        b    = mem[base + 2*k + 1] % (1 << 29);
      end else begin
        kind = mem[base + k] / (1 << 30);
        ac   = (mem[base + k] / (1 << 27)) % 8;
        a    = (mem[base + k] / (1 << 16)) % 2048;
        b    = mem[base + k] % 2048;
      end
      if (ac == 0) m = 0;
      else if (ac == 7) m = (id == a);
      else if (kind == 0) m = (a <= id) && (id <= b);
      else if (kind == 1) m = (id == a) || (id == b);
      else if (kind == 2) m = ((id & b) == (a & b));
      else m = 0;
      if (m) begin
        h = 1; act = int'(ac); idx = k;
        if (ac == 7) begin bi = int'(b % 64); sel = int'((b / 512) % 4); end
        lat = ex ? 2*k + 3 : k + 2;
        break;
      end
    end
  endtask

  task automatic run(input bit ex, input logic [28:0] idv, input bit poke, input string req);
    bit eh; int ea, ei, eb, es, el, n;
    model(ex, idv, eh, ea, ei, eb, es, el);
    win_lo = ex ? int'(ext_base_i) : int'(std_base_i);
    win_hi = win_lo + (ex ? 2*int'(ext_cnt_i) : int'(std_cnt_i));
    @(negedge clk);
    start_i = 1'b1; ext_i = ex; id_i = idv;
    @(negedge clk);
    n = 0;
    id_i = ~idv;                  // R12: changes after capture must not matter
    if (poke) begin               // R11: a start during a scan is ignored
      ext_i = ~ex;
      @(negedge clk);
      n = 1;
    end
    start_i = 1'b0;
    while (!done_o && n < 200) begin @(negedge clk); n++; end
    check(done_o && hit_o == eh && int'(action_o) == ea && int'(elem_idx_o) == ei &&
          int'(buf_idx_o) == eb && int'(dbg_sel_o) == es && n == el, req,
          $sformatf("ext=%0d id=%h got hit=%0d act=%0d idx=%0d buf=%0d sel=%0d lat=%0d exp hit=%0d act=%0d idx=%0d buf=%0d sel=%0d lat=%0d",
                    ex, idv, hit_o, action_o, elem_idx_o, buf_idx_o, dbg_sel_o, n,
                    eh, ea, ei, eb, es, el));
    @(negedge clk);
    check(!done_o, "R11", $sformatf("done lasted >1 cycle got=%0d exp=0", done_o));
  endtask

  task automatic put_ext(input int k, input logic [2:0] act, input logic [1:0] kind,
                         input logic [28:0] a, input logic [28:0] b);
    mem[int'(ext_base_i) + 2*k]     = {act, a};
    mem[int'(ext_base_i) + 2*k + 1] = {kind, 1'b1, b};   // bit 29 set: must be ignored (R4)
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    foreach (mem[i]) mem[i] = '0;
    // standard list at word 8 (R3): unused bits 15:11 set to junk in some
    mem[8]  = {2'b00, 3'b000, 11'h000, 5'b11111, 11'h7FF};   // disabled catch-all (R9)
    mem[9]  = 32'h081600F6;                                  // range 0x16..0xF6 FIFO0 (R5)
    mem[10] = 32'h500A00FF;                                  // dual 0x0A/0xFF FIFO1 (R6)
    mem[11] = {2'b10, 3'b111, 11'h7F0, 5'b10101, 2'b01, 3'b000, 6'd5}; // dedicated (R8)
    mem[12] = 32'h8E8B07F8;                                  // mask 0x68B/0x7F8 FIFO0 (R7)
    mem[13] = {2'b00, 3'b011, 11'h700, 5'b0, 11'h7FF};       // reject 0x700..0x7FF (R9)
    mem[14] = {2'b11, 3'b001, 11'h100, 5'b0, 11'h100};       // reserved kind (R7)
    mem[15] = {2'b00, 3'b010, 11'h0F0, 5'b0, 11'h0FF};       // overlaps range (R1)
    // extended list at word 0x40 (R4)
    put_ext(0, 3'b010, 2'b01, 29'h000AAAAA, 29'h000BBBBB);
    put_ext(1, 3'b111, 2'b11, 29'h00000123, {18'b0, 2'b10, 3'b0, 6'd2});
    put_ext(2, 3'b010, 2'b10, 29'h000FFFFF, 29'h1E0FFFFF);
    put_ext(3, 3'b001, 2'b00, 29'h000FFFFF, 29'h1FFFFFFF);
    put_ext(4, 3'b111, 2'b00, 29'h000AAAAA, 29'd1);          // shadowed by element 0 (R1)

    repeat (3) @(negedge clk);
    check(!done_o && !hit_o && !mem_rd_o, "R11", "reset state not idle");
    rst_n = 1'b1;
    @(negedge clk);

    // R10: empty lists
    std_cnt_i = 0; ext_cnt_i = 0;
    run(1'b0, 29'h16, 1'b0, "R10");
    run(1'b1, 29'hAAAAA, 1'b0, "R10");

    // R1 R3 R5 R6 R7 R8 R9 R12: full sweep of 11-bit identifiers, junk upper bits
    std_cnt_i = 8;
    for (int i = 0; i < 2048; i++)
      run(1'b0, {18'(i * 37 + 5), 11'(i)}, (i % 16) == 3, "R1/R5/R6/R7/R8/R9/R12");

    // R10 R2: shortened list, misses end earlier
    std_cnt_i = 3;
    for (int i = 0; i < 2048; i += 3) run(1'b0, 29'(i), 1'b0, "R10/R2");

    // R4 R5 R6 R7 R8: extended boundaries then pseudo-random identifiers
    ext_cnt_i = 5;
    run(1'b1, 29'h000FFFFE, 1'b0, "R5");
    run(1'b1, 29'h000FFFFF, 1'b0, "R7");
    run(1'b1, 29'h00100000, 1'b0, "R5");
    run(1'b1, 29'h01FFFFFF, 1'b0, "R7");
    run(1'b1, 29'h02000000, 1'b0, "R5");
    run(1'b1, 29'h1FFFFFFF, 1'b0, "R5");
    run(1'b1, 29'h000AAAAA, 1'b1, "R1/R6/R11");
    run(1'b1, 29'h000BBBBB, 1'b0, "R6");
    run(1'b1, 29'h00000123, 1'b0, "R8");
    run(1'b1, 29'h00000124, 1'b0, "R8");
    run(1'b1, 29'h0, 1'b0, "R10");
    x = 32'h1234567;
    for (int i = 0; i < 2500; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      run(1'b1, (i % 2 == 0) ? x[28:0] : {x[28:20], 20'hFFFFF}, 1'b0, "R4/R7");
    end

    check(rd_bad == 0, "R2", $sformatf("reads outside list window got=%0d exp=0", rd_bad));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule